// File: doc/BRIEF.md
# Partition Memory Region Checker

This block decides, in the same cycle as the access, whether a memory access issued by the processor may proceed. The processor runs one partition at a time. Each partition owns a small private table of address regions, and the check uses only the table of the partition named on the access. Every region has an inclusive lower and upper physical address, a valid bit, a code-or-data attribute, and read and write permissions. The block answers each access with either a grant or a fault. On a grant it also returns the index of the region that allowed the access.

The region tables are loaded through a write port that addresses one region slot of one partition at a time. A write takes effect only while the trusted-mode input is high. When trusted mode is low, the write is dropped and a one-cycle reject flag is raised on the next cycle. After reset every region is invalid, so every access faults until trusted software programs the tables.

The access check is purely combinational over registered tables, so a table write becomes visible to accesses from the cycle after the write edge.

Top module: `partition_region_checker`

## Requirements
- R1: After reset every region is invalid. Every access therefore faults until a trusted table write validates a region.
- R2: Region bounds are inclusive. An address equal to the base or to the limit can be granted. The address one below the base and the address one above the limit do not match that region.
- R3: A region whose base is greater than its limit never matches any address.
- R4: The access kind is encoded on `acc_kind` as 0 = instruction fetch, 1 = data read, 2 = data write. A fetch can be granted only by a region with the code attribute set. A data read or data write can be granted only by a region with the code attribute clear.
- R5: A data read requires the region's read permission. A data write requires the region's write permission. A region that lacks the needed permission does not grant, even when it contains the address.
- R6: Only the regions of the partition given on `acc_part` take part in the check. Regions of every other partition are ignored.
- R7: When several regions grant the access, `acc_hit_idx` reports the lowest-numbered granting region. A lower-numbered region that contains the address but does not permit the access is skipped.
- R8: A table write with `cfg_trusted` low leaves the tables unchanged, and `cfg_reject` is high for exactly the following cycle. A write with `cfg_trusted` high updates the addressed slot and does not raise `cfg_reject`.
- R9: While `acc_valid` is high, exactly one of `acc_grant` and `acc_fault` is high, in the same cycle. While `acc_valid` is low, both are low.
- R10: The reserved access kind 3 always faults.
- R11: A region written with its valid bit clear never matches, even if its bounds and attributes would otherwise grant the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 fetch, 1 data read, 2 data write, 3 reserved |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_part | input | PART_W | Partition that is currently active |
| cfg_we | input | 1 | Table write strobe |
| cfg_trusted | input | 1 | Trusted mode; table writes take effect only while high |
| cfg_part | input | PART_W | Partition whose table is written |
| cfg_slot | input | SLOT_W | Region slot within that table |
| cfg_base | input | ADDR_W | Inclusive lower bound to store |
| cfg_limit | input | ADDR_W | Inclusive upper bound to store |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_code | input | 1 | Code attribute to store (1 = code, 0 = data) |
| cfg_rd | input | 1 | Read permission to store |
| cfg_wr | input | 1 | Write permission to store |
| acc_grant | output | 1 | Access allowed |
| acc_fault | output | 1 | Access refused |
| acc_hit_idx | output | SLOT_W | Lowest granting region; 0 when there is no grant |
| cfg_reject | output | 1 | One-cycle flag that a non-trusted table write was dropped |

## Verification
The embedded properties check the following on every cycle:
- Grant and fault are mutually exclusive and tied to `acc_valid`.
- A reported index always points at a region that grants.
- An inverted region never matches.
- A fetch never matches a data region.
- The reserved kind never matches.
- A non-trusted write leaves all three table arrays unchanged and raises the reject flag.

Only the directed scenarios can show the following:
- Inclusive-bound arithmetic at the exact edge addresses.
- The choice of the lowest granting region among overlapping ones.
- Isolation between partitions.
- The all-fault state after reset.
- The effect of clearing a valid bit.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic [1:0] {
        AK_FETCH = 2'd0,
        AK_READ  = 2'd1,
        AK_WRITE = 2'd2,
        AK_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic valid;
        logic code;
        logic rd;
        logic wr;
    } reg_attr_t;

endpackage

// File: rtl/prc_region_table.sv
module prc_region_table
    import prc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_PART = 4,
    parameter int NSLOT    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic                               cfg_trusted,
    input  logic [$clog2(NUM_PART)-1:0]        cfg_part,
    input  logic [$clog2(NSLOT)-1:0]           cfg_slot,
    input  logic [ADDR_W-1:0]                  cfg_base,
    input  logic [ADDR_W-1:0]                  cfg_limit,
    input  reg_attr_t                          cfg_attr,
    input  logic [$clog2(NUM_PART)-1:0]        rd_part,
    output logic [NSLOT-1:0][ADDR_W-1:0]       cur_base,
    output logic [NSLOT-1:0][ADDR_W-1:0]       cur_limit,
    output reg_attr_t [NSLOT-1:0]              cur_attr,
    output logic                               cfg_reject
);
    localparam int PART_W = $clog2(NUM_PART);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int NENT   = NUM_PART * NSLOT;
    localparam int IDX_W  = PART_W + SLOT_W;

    logic [NENT-1:0][ADDR_W-1:0] base_q;
    logic [NENT-1:0][ADDR_W-1:0] limit_q;
    reg_attr_t [NENT-1:0]        attr_q;

    logic [IDX_W-1:0] wr_idx;
    logic             wr_ok;

    assign wr_idx = {cfg_part, cfg_slot};
    assign wr_ok  = cfg_we && cfg_trusted;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            limit_q    <= '0;
            attr_q     <= '0;
            cfg_reject <= 1'b0;
        end else begin
            cfg_reject <= cfg_we && !cfg_trusted;
            if (wr_ok) begin
                base_q[wr_idx]  <= cfg_base;
                limit_q[wr_idx] <= cfg_limit;
                attr_q[wr_idx]  <= cfg_attr;
            end
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_rdport
        localparam logic [SLOT_W-1:0] SI = SLOT_W'(s);
        assign cur_base[s]  = base_q[{rd_part, SI}];
        assign cur_limit[s] = limit_q[{rd_part, SI}];
        assign cur_attr[s]  = attr_q[{rd_part, SI}];
    end

    // R8: a dropped write leaves the tables intact and is flagged next cycle
    a_r8_untrusted_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_trusted) |=> ($stable(base_q) && $stable(limit_q) && $stable(attr_q)));
    a_r8_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_trusted) |=> cfg_reject);

endmodule

// File: rtl/prc_region_match.sv
module prc_region_match
    import prc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  reg_attr_t         attr,
    output logic              ok
);
    logic in_range;
    logic perm;

    assign in_range = (addr >= base) && (addr <= limit);

    always_comb begin
        unique case (kind)
            AK_FETCH: perm = attr.code;
            AK_READ:  perm = !attr.code && attr.rd;
            AK_WRITE: perm = !attr.code && attr.wr;
            default:  perm = 1'b0;
        endcase
    end

    assign ok = attr.valid && in_range && perm;

    // R3: inverted bounds never grant
    a_r3_inverted_never: assert property (@(posedge clk) disable iff (!rst_n)
        (base > limit) |-> !ok);
    // R4: a fetch only ever matches a code region
    a_r4_fetch_code_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && kind == AK_FETCH) |-> attr.code);
    // R10: the reserved kind never matches
    a_r10_rsvd_never: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == AK_RSVD) |-> !ok);
    // R11: an invalid region never matches
    a_r11_invalid_never: assert property (@(posedge clk) disable iff (!rst_n)
        !attr.valid |-> !ok);

endmodule

// File: rtl/prc_low_pick.sv
module prc_low_pick #(
    parameter int NSLOT = 8
) (
    input  logic [NSLOT-1:0]         hits,
    output logic                     any,
    output logic [$clog2(NSLOT)-1:0] idx
);
    localparam int SLOT_W = $clog2(NSLOT);

    always_comb begin
        idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (hits[i]) idx = SLOT_W'(i);
        end
    end

    assign any = |hits;

endmodule

// File: rtl/partition_region_checker.sv
module partition_region_checker
    import prc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_PART = 4,
    parameter int NSLOT    = 8,
    localparam int PART_W  = $clog2(NUM_PART),
    localparam int SLOT_W  = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PART_W-1:0] acc_part,
    input  logic              cfg_we,
    input  logic              cfg_trusted,
    input  logic [PART_W-1:0] cfg_part,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              cfg_valid,
    input  logic              cfg_code,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    output logic              acc_grant,
    output logic              acc_fault,
    output logic [SLOT_W-1:0] acc_hit_idx,
    output logic              cfg_reject
);
    logic [NSLOT-1:0][ADDR_W-1:0] cur_base;
    logic [NSLOT-1:0][ADDR_W-1:0] cur_limit;
    reg_attr_t [NSLOT-1:0]        cur_attr;
    reg_attr_t                    wr_attr;
    logic [NSLOT-1:0]             slot_ok;
    logic                         any_ok;
    logic [SLOT_W-1:0]            pick_idx;

    assign wr_attr = '{valid: cfg_valid, code: cfg_code, rd: cfg_rd, wr: cfg_wr};

    prc_region_table #(.ADDR_W(ADDR_W), .NUM_PART(NUM_PART), .NSLOT(NSLOT)) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_trusted(cfg_trusted),
        .cfg_part(cfg_part), .cfg_slot(cfg_slot),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_attr(wr_attr),
        .rd_part(acc_part),
        .cur_base(cur_base), .cur_limit(cur_limit), .cur_attr(cur_attr),
        .cfg_reject(cfg_reject)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_match
        prc_region_match #(.ADDR_W(ADDR_W)) u_match (
            .clk(clk), .rst_n(rst_n),
            .addr(acc_addr), .kind(acc_kind),
            .base(cur_base[s]), .limit(cur_limit[s]), .attr(cur_attr[s]),
            .ok(slot_ok[s])
        );
    end

    prc_low_pick #(.NSLOT(NSLOT)) u_pick (
        .hits(slot_ok), .any(any_ok), .idx(pick_idx)
    );

    assign acc_grant   = acc_valid && any_ok;
    assign acc_fault   = acc_valid && !any_ok;
    assign acc_hit_idx = acc_grant ? pick_idx : '0;

    // R9: one verdict per valid access, none while idle
    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $onehot({acc_grant, acc_fault}));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_grant && !acc_fault));
    // R7: the reported index names a region that grants
    a_r7_idx_grants: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> slot_ok[acc_hit_idx]);

endmodule

// File: tb/tb_partition_region_checker.sv
module tb_partition_region_checker;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_part = '0;
    logic        cfg_we = 1'b0, cfg_trusted = 1'b0;
    logic [1:0]  cfg_part = '0;
    logic [2:0]  cfg_slot = '0;
    logic [31:0] cfg_base = '0, cfg_limit = '0;
    logic        cfg_valid = 1'b0, cfg_code = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic        acc_grant, acc_fault, cfg_reject;
    logic [2:0]  acc_hit_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    partition_region_checker #(.ADDR_W(ADDR_W), .NUM_PART(4), .NSLOT(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_part(acc_part),
        .cfg_we(cfg_we), .cfg_trusted(cfg_trusted), .cfg_part(cfg_part), .cfg_slot(cfg_slot),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
        .cfg_code(cfg_code), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .acc_grant(acc_grant), .acc_fault(acc_fault), .acc_hit_idx(acc_hit_idx),
        .cfg_reject(cfg_reject)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_region(input logic trusted, input logic [1:0] p, input logic [2:0] s,
                             input logic [31:0] b, input logic [31:0] l,
                             input logic v, input logic c, input logic r, input logic w,
                             input logic exp_rej);
        @(negedge clk);
        cfg_we = 1'b1; cfg_trusted = trusted; cfg_part = p; cfg_slot = s;
        cfg_base = b; cfg_limit = l; cfg_valid = v; cfg_code = c; cfg_rd = r; cfg_wr = w;
        @(negedge clk);
        cfg_we = 1'b0; cfg_trusted = 1'b0;
        chk("R8 reject flag", {31'd0, cfg_reject}, {31'd0, exp_rej});
    endtask

    // exp_idx is only compared on a grant
    task automatic access(input string tag, input logic [1:0] p, input logic [1:0] k,
                          input logic [31:0] a, input logic exp_g, input logic [2:0] exp_idx);
        @(negedge clk);
        acc_valid = 1'b1; acc_part = p; acc_kind = k; acc_addr = a;
        #1;
        chk({tag, " grant"}, {31'd0, acc_grant}, {31'd0, exp_g});
        chk({tag, " fault"}, {31'd0, acc_fault}, {31'd0, !exp_g});
        if (exp_g) chk({tag, " index"}, {29'd0, acc_hit_idx}, {29'd0, exp_idx});
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        access("R1 post-reset read", 2'd0, 2'd1, 32'h2000, 1'b0, 3'd0);
        access("R1 post-reset fetch", 2'd1, 2'd0, 32'h0, 1'b0, 3'd0);
        chk("R8 no reject at reset", {31'd0, cfg_reject}, 32'd0);
    endtask

    task automatic t_program();
        wr_region(1'b1, 2'd0, 3'd2, 32'h2000, 32'h2FFF, 1, 0, 1, 0, 1'b0);
        wr_region(1'b1, 2'd0, 3'd3, 32'h2800, 32'h28FF, 1, 0, 1, 1, 1'b0);
        wr_region(1'b1, 2'd0, 3'd5, 32'h8000, 32'h80FF, 1, 1, 1, 0, 1'b0);
        wr_region(1'b1, 2'd0, 3'd6, 32'h9000, 32'h8FFF, 1, 0, 1, 1, 1'b0);
        wr_region(1'b1, 2'd1, 3'd0, 32'h2000, 32'h2FFF, 1, 0, 1, 1, 1'b0);
    endtask

    task automatic t_bounds();
        access("R2 base", 2'd0, 2'd1, 32'h2000, 1'b1, 3'd2);
        access("R2 limit", 2'd0, 2'd1, 32'h2FFF, 1'b1, 3'd2);
        access("R2 below base", 2'd0, 2'd1, 32'h1FFF, 1'b0, 3'd0);
        access("R2 above limit", 2'd0, 2'd1, 32'h3000, 1'b0, 3'd0);
        access("R3 inverted at base", 2'd0, 2'd1, 32'h9000, 1'b0, 3'd0);
        access("R3 inverted at limit", 2'd0, 2'd2, 32'h8FFF, 1'b0, 3'd0);
    endtask

    task automatic t_kinds();
        access("R4 fetch from data", 2'd0, 2'd0, 32'h2000, 1'b0, 3'd0);
        access("R4 fetch from code", 2'd0, 2'd0, 32'h8000, 1'b1, 3'd5);
        access("R4 read from code", 2'd0, 2'd1, 32'h80FF, 1'b0, 3'd0);
        access("R5 write read-only", 2'd0, 2'd2, 32'h2000, 1'b0, 3'd0);
        access("R10 reserved kind", 2'd0, 2'd3, 32'h2810, 1'b0, 3'd0);
    endtask

    task automatic t_priority();
        access("R7 read overlap", 2'd0, 2'd1, 32'h2810, 1'b1, 3'd2);
        access("R7 write skips slot2", 2'd0, 2'd2, 32'h2810, 1'b1, 3'd3);
    endtask

    task automatic t_partitions();
        access("R6 part1 write", 2'd1, 2'd2, 32'h2000, 1'b1, 3'd0);
        access("R6 part1 fetch", 2'd1, 2'd0, 32'h8000, 1'b0, 3'd0);
        access("R6 part2 read", 2'd2, 2'd1, 32'h2000, 1'b0, 3'd0);
    endtask

    task automatic t_untrusted();
        wr_region(1'b0, 2'd2, 3'd0, 32'h0, 32'hFFFF, 1, 0, 1, 1, 1'b1);
        access("R8 dropped write", 2'd2, 2'd1, 32'h10, 1'b0, 3'd0);
        chk("R8 reject one cycle", {31'd0, cfg_reject}, 32'd0);
        wr_region(1'b0, 2'd1, 3'd0, 32'h0, 32'h0, 0, 0, 0, 0, 1'b1);
        access("R8 part1 intact", 2'd1, 2'd1, 32'h2FFF, 1'b1, 3'd0);
    endtask

    task automatic t_invalidate();
        wr_region(1'b1, 2'd1, 3'd0, 32'h2000, 32'h2FFF, 0, 0, 1, 1, 1'b0);
        access("R11 cleared valid", 2'd1, 2'd2, 32'h2000, 1'b0, 3'd0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_part = 2'd0; acc_kind = 2'd1; acc_addr = 32'h2000;
        #1;
        chk("R9 idle grant", {31'd0, acc_grant}, 32'd0);
        chk("R9 idle fault", {31'd0, acc_fault}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_program();
        t_bounds();
        t_kinds();
        t_priority();
        t_partitions();
        t_untrusted();
        t_invalidate();
        t_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule